// File: doc/BRIEF.md
# Input-Capture Buffering and Flag Control

This block owns the capture side of a timer with eight capture channels. Each channel stores a snapshot of a free-running timer whenever its edge strobe fires. Edge detection is done upstream and arrives here as one-cycle strobes. The lower four channels each have a holding register behind the capture register. The upper four are plain partner channels, and an upper channel can be made to follow the pin of its lower partner.

A single control byte sets the behaviour. The holding registers can be switched off. They can work as a two-deep queue, where each new capture pushes the previous timestamp into the holding register. They can also work in latch mode, where an external strobe copies all four capture registers into their holding registers at the same instant. The flag policy chooses when a buffered channel's flag rises: on every capture, or only when the holding register is filled in queue mode. Software clears flags by writing ones.

Top module: `icap_buffer_ctrl`

## Requirements
- R1: After reset, the control byte, all capture registers, all holding registers and all flags are zero.
- R2: A control write stores the byte, which reads back on `ctrl_q` in the next cycle and takes effect from that cycle on. The bit fields are:
  - bits 7..4: partner-follow enables for inputs 3..0.
  - bit 3: flag policy.
  - bit 2: saturate option, which is stored only.
  - bit 1: buffer enable.
  - bit 0: latch select.
- R3: An edge strobe on channel c loads the current timer value into capture register c. The value is visible after the next clock edge. Channel c occupies bits `c*16 +: 16` of `cap_q`.
- R4: When follow enable k is 1, a strobe on input k (k = 0..3) also captures into channel k+4. When it is 0, input k has no effect on channel k+4.
- R5: In queue mode (buffer enable 1, latch select 0), a capture on a buffered channel whose capture register is occupied copies the old capture value into its holding register. This happens in the same edge that loads the new timestamp.
- R6: Occupancy is cleared whenever queue mode is off. The first capture after queue mode begins loads only the capture register and leaves the holding register unchanged.
- R7: With flag policy 0, or outside queue mode, a channel's flag is set on every capture. The partner channels 4..7 always follow this rule.
- R8: With flag policy 1 in queue mode, flags 0..3 are set only when the matching holding register is loaded.
- R9: In latch mode (buffer enable 1, latch select 1), the latch strobe copies capture registers 0..3 into holding registers 0..3. If a capture happens in the same cycle, the pre-capture value is copied. Outside latch mode the strobe has no effect.
- R10: While buffer enable is 0, all holding registers read zero from the next edge on.
- R11: A 1 in `flag_clr` clears that flag. If a set and a clear of the same flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr | input | 16 | Free-running timer value |
| edge_stb | input | 8 | Qualified edge strobe per channel |
| latch_stb | input | 1 | Latch-mode transfer strobe |
| ctrl_we | input | 1 | Control byte write enable |
| ctrl_wdata | input | 8 | Control byte write data |
| flag_clr | input | 8 | Write-one-to-clear flag strobes |
| ctrl_q | output | 8 | Current control byte |
| cap_q | output | 128 | Capture registers, channel c at bits c*16 +: 16 |
| hold_q | output | 64 | Holding registers, channel c at bits c*16 +: 16 |
| flag_q | output | 8 | Capture flags |

## Verification
The bench builds the block with its default parameters: a 16-bit timer and four buffered channels, which gives eight channels in total. With that configuration every follow bit has a real partner channel, and the queue, latch and disabled buffering modes can all be reached from random control writes. Random timer values make stale and fresh timestamps easy to tell apart. This makes the queue push order and the copy of the pre-capture value on a same-cycle latch observable.

// File: rtl/icb_pkg.sv
package icb_pkg;
   typedef struct packed {
      logic [3:0] follow;
      logic       flag_md;
      logic       sat_max;
      logic       buf_en;
      logic       latch_sel;
   } icb_ctrl_t;
endpackage

// File: rtl/icb_ctrl.sv
module icb_ctrl
   import icb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output icb_ctrl_t  ctrl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (we) ctrl_q <= icb_ctrl_t'(wdata);
   end

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ctrl_q == icb_ctrl_t'($past(wdata))));
endmodule

// File: rtl/icb_cap.sv
module icb_cap #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev,
   input  logic [TS_W-1:0] tmr,
   output logic [TS_W-1:0] cap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cap_q <= '0;
      else if (ev) cap_q <= tmr;
   end

   assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> (cap_q == $past(tmr)));
endmodule

// File: rtl/icb_hold.sv
module icb_hold #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ev,
   input  logic [TS_W-1:0] cap_in,
   input  logic            buf_en,
   input  logic            latch_sel,
   input  logic            latch_stb,
   output logic [TS_W-1:0] hold_q,
   output logic            hold_ld
);
   logic queue_md, latch_md, full_q;

   assign queue_md = buf_en & ~latch_sel;
   assign latch_md = buf_en & latch_sel;
   assign hold_ld  = queue_md & ev & full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else begin
         full_q <= queue_md & (full_q | ev);
         if (!buf_en)                    hold_q <= '0;
         else if (hold_ld)               hold_q <= cap_in;
         else if (latch_md && latch_stb) hold_q <= cap_in;
      end
   end

   assert_queue_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_md && ev && full_q) |=> (hold_q == $past(cap_in)));
   assert_first_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_md && ev && !full_q) |=> $stable(hold_q));
   assert_latch_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_md && latch_stb) |=> (hold_q == $past(cap_in)));
   assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en |=> (hold_q == '0));
endmodule

// File: rtl/icb_flags.sv
module icb_flags #(
   parameter int NUM_CH  = 8,
   parameter int NUM_BUF = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  ev,
   input  logic [NUM_BUF-1:0] hold_ld,
   input  logic               hold_policy,
   input  logic [NUM_CH-1:0]  clr,
   output logic [NUM_CH-1:0]  flag_q
);
   logic [NUM_CH-1:0] set;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_set
      if (c < NUM_BUF) begin : g_buf
         assign set[c] = hold_policy ? hold_ld[c] : ev[c];
         assert_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_policy && ev[c] && !hold_ld[c] && !flag_q[c]) |=> !flag_q[c]);
      end else begin : g_plain
         assign set[c] = ev[c];
      end
      assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
         set[c] |=> flag_q[c]);
      assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[c] && !set[c]) |=> !flag_q[c]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr) | set;
   end
endmodule

// File: rtl/icap_buffer_ctrl.sv
module icap_buffer_ctrl
   import icb_pkg::*;
#(
   parameter int TS_W    = 16,
   parameter int NUM_BUF = 4,
   localparam int NUM_CH = 2 * NUM_BUF
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [TS_W-1:0]         tmr,
   input  logic [NUM_CH-1:0]       edge_stb,
   input  logic                    latch_stb,
   input  logic                    ctrl_we,
   input  logic [7:0]              ctrl_wdata,
   input  logic [NUM_CH-1:0]       flag_clr,
   output logic [7:0]              ctrl_q,
   output logic [NUM_CH*TS_W-1:0]  cap_q,
   output logic [NUM_BUF*TS_W-1:0] hold_q,
   output logic [NUM_CH-1:0]       flag_q
);
   if (NUM_BUF != 4) begin : g_bad_buf
      $error("icap_buffer_ctrl: the control byte supports exactly four buffered channels");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("icap_buffer_ctrl: timer width too small");
   end

   icb_ctrl_t          ctrl;
   logic [NUM_CH-1:0]  ev;
   logic [NUM_BUF-1:0] hold_ld;
   logic               hold_policy;

   icb_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (ctrl_wdata),
      .ctrl_q (ctrl)
   );

   assign ctrl_q      = ctrl;
   assign hold_policy = ctrl.flag_md & ctrl.buf_en & ~ctrl.latch_sel;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c < NUM_BUF) begin : g_buffered
         assign ev[c] = edge_stb[c];
         icb_hold #(.TS_W(TS_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev        (ev[c]),
            .cap_in    (cap_q[c*TS_W +: TS_W]),
            .buf_en    (ctrl.buf_en),
            .latch_sel (ctrl.latch_sel),
            .latch_stb (latch_stb),
            .hold_q    (hold_q[c*TS_W +: TS_W]),
            .hold_ld   (hold_ld[c])
         );
      end else begin : g_partner
         assign ev[c] = edge_stb[c] | (ctrl.follow[c-NUM_BUF] & edge_stb[c-NUM_BUF]);
         assert_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl.follow[c-NUM_BUF] && edge_stb[c-NUM_BUF])
               |=> (cap_q[c*TS_W +: TS_W] == $past(tmr)));
      end
      icb_cap #(.TS_W(TS_W)) u_cap (
         .clk   (clk),
         .rst_n (rst_n),
         .ev    (ev[c]),
         .tmr   (tmr),
         .cap_q (cap_q[c*TS_W +: TS_W])
      );
   end

   icb_flags #(.NUM_CH(NUM_CH), .NUM_BUF(NUM_BUF)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .hold_ld     (hold_ld),
      .hold_policy (hold_policy),
      .clr         (flag_clr),
      .flag_q      (flag_q)
   );
endmodule

// File: tb/icap_buffer_ctrl_bench.sv
module icap_buffer_ctrl_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  tmr = '0;
   logic [7:0]   edge_stb = '0;
   logic         latch_stb = 1'b0;
   logic         ctrl_we = 1'b0;
   logic [7:0]   ctrl_wdata = '0;
   logic [7:0]   flag_clr = '0;
   logic [7:0]   ctrl_q;
   logic [127:0] cap_q;
   logic [63:0]  hold_q;
   logic [7:0]   flag_q;

   int n_vec = 0;
   int n_bad = 0;

   logic [7:0]  m_ctrl;
   logic [15:0] m_cap [8];
   logic [15:0] m_hold [4];
   logic [3:0]  m_full;
   logic [7:0]  m_flag;

   always #2 clk = ~clk;

   icap_buffer_ctrl u_icap_buffer_ctrl (
      .clk(clk), .rst_n(rst_n), .tmr(tmr), .edge_stb(edge_stb),
      .latch_stb(latch_stb), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .flag_clr(flag_clr), .ctrl_q(ctrl_q), .cap_q(cap_q),
      .hold_q(hold_q), .flag_q(flag_q)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // expected next state from requirements R2..R11
   task automatic model_step();
      logic be, lt, q, l, fm;
      logic [7:0] ev, set;
      be = m_ctrl[1]; lt = m_ctrl[0]; fm = m_ctrl[3];
      q = be & ~lt; l = be & lt;
      ev = edge_stb;
      for (int k = 0; k < 4; k++) ev[k+4] = edge_stb[k+4] | (m_ctrl[4+k] & edge_stb[k]);
      set = ev;
      for (int k = 0; k < 4; k++) begin
         logic ld;
         ld = q & ev[k] & m_full[k];
         if (!be)                m_hold[k] = '0;
         else if (ld)            m_hold[k] = m_cap[k];
         else if (l & latch_stb) m_hold[k] = m_cap[k];
         m_full[k] = q & (m_full[k] | ev[k]);
         if (fm & q) set[k] = ld;
      end
      for (int c = 0; c < 8; c++) if (ev[c]) m_cap[c] = tmr;
      m_flag = (m_flag & ~flag_clr) | set;
      if (ctrl_we) m_ctrl = ctrl_wdata;
   endtask

   task automatic check_all(input string tag);
      chk({24'd0, ctrl_q}, {24'd0, m_ctrl}, {tag, " ctrl R2"});
      for (int c = 0; c < 8; c++) chk({16'd0, cap_q[c*16 +: 16]}, {16'd0, m_cap[c]}, {tag, " cap R3"});
      for (int k = 0; k < 4; k++) chk({16'd0, hold_q[k*16 +: 16]}, {16'd0, m_hold[k]}, {tag, " hold R5"});
      chk({24'd0, flag_q}, {24'd0, m_flag}, {tag, " flag R7"});
   endtask

   task automatic step(input logic [15:0] t, input logic [7:0] e, input logic ls,
                       input logic cwe, input logic [7:0] cd, input logic [7:0] clr,
                       input string tag);
      @(negedge clk);
      tmr = t; edge_stb = e; latch_stb = ls; ctrl_we = cwe; ctrl_wdata = cd; flag_clr = clr;
      model_step();
      @(negedge clk);
      edge_stb = '0; latch_stb = 1'b0; ctrl_we = 1'b0; flag_clr = '0;
      check_all(tag);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      m_ctrl = '0; m_full = '0; m_flag = '0;
      for (int c = 0; c < 8; c++) m_cap[c] = '0;
      for (int k = 0; k < 4; k++) m_hold[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
      chk({24'd0, flag_q}, 32'd0, "R1 flags");

      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'hA5, 8'h00, "R2 write");
      chk({24'd0, ctrl_q}, 32'h0000_00A5, "R2 readback");
      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, "R2 zero");

      step(16'h1234, 8'h04, 1'b0, 1'b0, 8'h00, 8'h00, "R3 cap");
      chk({16'd0, cap_q[32 +: 16]}, 32'h1234, "R3 ch2");
      chk({24'd0, flag_q}, 32'h04, "R7 flag on capture");

      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h20, 8'h00, "R4 setup");
      step(16'h5555, 8'h02, 1'b0, 1'b0, 8'h00, 8'h00, "R4 follow");
      chk({16'd0, cap_q[80 +: 16]}, 32'h5555, "R4 ch5 follows");
      chk({16'd0, cap_q[64 +: 16]}, 32'h0000, "R4 ch4 untouched");

      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h0A, 8'hFF, "R8 setup");
      step(16'h1111, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, "R6 first");
      chk({16'd0, hold_q[0 +: 16]}, 32'h0, "R6 hold kept");
      chk({31'd0, flag_q[0]}, 32'd0, "R8 no flag on first");
      step(16'h2222, 8'h01, 1'b0, 1'b0, 8'h00, 8'h00, "R5 push");
      chk({16'd0, hold_q[0 +: 16]}, 32'h1111, "R5 old value");
      chk({16'd0, cap_q[0 +: 16]}, 32'h2222, "R5 new value");
      chk({31'd0, flag_q[0]}, 32'd1, "R8 flag on hold load");

      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h03, 8'h00, "R9 setup");
      step(16'h7777, 8'h04, 1'b1, 1'b0, 8'h00, 8'h00, "R9 latch");
      chk({16'd0, hold_q[16 +: 16]}, 32'h5555, "R9 hold1");
      chk({16'd0, hold_q[32 +: 16]}, 32'h1234, "R9 hold2 pre-capture");

      step(16'h0000, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, "R10 off");
      step(16'h0000, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, "R10 idle");
      chk({hold_q[63:32] | hold_q[31:0]}, 32'h0, "R10 holds zero");

      step(16'h4321, 8'h01, 1'b0, 1'b0, 8'h00, 8'h01, "R11 set wins");
      chk({31'd0, flag_q[0]}, 32'd1, "R11 set wins");
      step(16'h0000, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, "R11 clear");
      chk({31'd0, flag_q[0]}, 32'd0, "R11 cleared");

      void'($urandom(32'h1CE5));
      for (int i = 0; i < 1500; i++) begin
         logic cw;
         cw = (($urandom % 8) == 0);
         step(16'($urandom), 8'($urandom) & 8'($urandom), (($urandom % 4) == 0),
              cw, 8'($urandom), (($urandom % 3) == 0) ? 8'($urandom) : 8'h00, "random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule